// File: doc/BRIEF.md
# Direct-Store Segment Access Checker

This block sits in the address-translation path of a 32-bit core. It decides every access whose segment is marked as a direct-store (I/O) segment, and it also enforces the per-segment no-execute rule on instruction fetches. The upper four bits of the effective address pick one of sixteen segment descriptors, which come in on a flat bus. From that descriptor, the access direction, the access class and the privilege level, the block chooses one outcome: grant the access with an identity physical address, raise a typed fault with a syndrome value and a fault address, or hand the access on to the hashed page walk.

The result is registered. A request presented on one clock edge produces a response, with `rsp_valid` high, on the next edge. Cache-management operations that target a direct-store segment complete quietly as no-ops. When translation is off (real mode), the checks are skipped and the access is granted in full.

Top module: `ds_access_checker`

## Requirements
- R1: Effective address bits [31:28] select the descriptor that governs an access. Descriptor n occupies bits [32n+31:32n] of `seg_file`. In a descriptor, bit 31 is the direct-store flag, bit 30 the supervisor key, bit 29 the user key and bit 28 the no-execute flag.
- R2: With `req_real` high, the response is a grant with read, write and execute permission and `rsp_pa` equal to the effective address. The descriptor is ignored. `rsp_ex` is high only in this case.
- R3: An instruction fetch (`req_kind`=2) to a direct-store segment gives an instruction fault (`rsp_fault`=1) with syndrome 0x10000000, whatever the access class.
- R4: An instruction fetch to a segment that is not direct-store but has the no-execute flag set gives an instruction fault with syndrome 0x10000000.
- R5: Any other access to a segment that is not direct-store sets `rsp_walk` with no grant and no fault. On every response, exactly one of grant, walk or fault is reported.
- R6: A floating-point access (class 1) to a direct-store segment gives an alignment fault (`rsp_fault`=3). The syndrome is the parameter `ALIGN_FP_CODE` (default 0x00010000) and `rsp_far` is the effective address.
- R7: A reservation access (class 2) to a direct-store segment gives a data fault (`rsp_fault`=2). The syndrome is 0x06000000 for a store (`req_kind`=1) and 0x04000000 for a load (`req_kind`=0). `rsp_far` is the effective address.
- R8: An external-control access (class 4) to a direct-store segment gives a data fault with syndrome 0x06100000 for a store or 0x04100000 for a load. `rsp_far` is the effective address.
- R9: A cache-management access (class 3) to a direct-store segment is granted with `rsp_pa` equal to the effective address and no read or write permission, whatever the direction or key.
- R10: An integer access (class 0, and also classes 5 to 7) takes its key from the user-key bit when `req_user` is 1 and from the supervisor-key bit otherwise. Key 1 grants read and write. Key 0 grants read only, so a store faults as a data fault with syndrome 0x0A000000 and `rsp_far` set to the effective address. A granted access has `rsp_pa` equal to the effective address.
- R11: `rsp_valid` is high exactly on the cycle after a cycle with `req_valid` high. When there is no fault, `rsp_syndrome` and `rsp_far` are zero. When there is no grant, `rsp_pa` is zero.
- R12: While `rst_n` is low, `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | 0 load, 1 store, 2 instruction fetch |
| req_class | input | 3 | 0 integer, 1 float, 2 reservation, 3 cache op, 4 external control |
| req_user | input | 1 | 1 for user-mode access, 0 for privileged |
| req_real | input | 1 | Translation disabled |
| seg_file | input | 512 | Sixteen 32-bit segment descriptors |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Access granted |
| rsp_walk | output | 1 | Forward to the hashed page walk |
| rsp_fault | output | 2 | 0 none, 1 instruction, 2 data, 3 alignment |
| rsp_pa | output | 32 | Physical address on grant |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_ex | output | 1 | Execute permitted |
| rsp_syndrome | output | 32 | Fault syndrome code |
| rsp_far | output | 32 | Captured fault address |

## Verification
The bench aims at the class-versus-direction matrix. A design that swapped the store and load syndromes, or mixed up the reservation and external-control codes, would report the wrong code on at least one table row. Key selection is checked in both privilege modes on two segments whose key bits are opposite, so a design that read the wrong key bit would grant a store it should refuse. The bench also confirms that a fetch wins over the access class on a direct-store segment, that the no-execute flag matters only for fetches, and that real mode overrides a direct-store descriptor. It checks that cache operations are granted even when the key would refuse a store, and that a mis-sliced descriptor index would pick another segment's flags.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int ADDR_W  = 32;
  localparam int DESC_W  = 32;
  localparam int SEL_W   = 4;
  localparam int NUM_SEG = 1 << SEL_W;

  // descriptor bit positions
  localparam int BIT_DS  = 31;
  localparam int BIT_KS  = 30;
  localparam int BIT_KU  = 29;
  localparam int BIT_NX  = 28;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    CLS_INT   = 3'd0,
    CLS_FP    = 3'd1,
    CLS_RESV  = 3'd2,
    CLS_CACHE = 3'd3,
    CLS_EXT   = 3'd4
  } class_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_INSTR = 2'd1,
    FLT_DATA  = 2'd2,
    FLT_ALIGN = 2'd3
  } fault_e;

  localparam logic [31:0] SYN_NOEXEC  = 32'h1000_0000;
  localparam logic [31:0] SYN_RESV_ST = 32'h0600_0000;
  localparam logic [31:0] SYN_RESV_LD = 32'h0400_0000;
  localparam logic [31:0] SYN_EXT_ST  = 32'h0610_0000;
  localparam logic [31:0] SYN_EXT_LD  = 32'h0410_0000;
  localparam logic [31:0] SYN_PROT_ST = 32'h0A00_0000;

  typedef struct packed {
    logic              ok;
    logic              walk;
    fault_e            fault;
    logic [ADDR_W-1:0] pa;
    logic              rd;
    logic              wr;
    logic              ex;
    logic [31:0]       syn;
    logic [ADDR_W-1:0] far;
  } dsc_rsp_t;
endpackage

// File: rtl/dsc_seg_select.sv
module dsc_seg_select #(
  parameter int SEL_W  = 4,
  parameter int DESC_W = 32,
  localparam int NUM_SEG = 1 << SEL_W
) (
  input  logic [NUM_SEG*DESC_W-1:0] seg_file,
  input  logic [SEL_W-1:0]          sel,
  output logic [DESC_W-1:0]         desc
);
  logic [DESC_W-1:0] entry [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_slice
    assign entry[g] = seg_file[g*DESC_W +: DESC_W];
  end

  assign desc = entry[sel];
endmodule

// File: rtl/dsc_decide.sv
module dsc_decide
  import dsc_pkg::*;
#(
  parameter logic [31:0] ALIGN_FP_CODE = 32'h0001_0000
) (
  input  logic [ADDR_W-1:0] ea,
  input  logic [DESC_W-1:0] desc,
  input  logic [1:0]        kind,
  input  logic [2:0]        cls,
  input  logic              user,
  input  logic              real_mode,
  output dsc_rsp_t          rsp
);
  logic is_fetch, is_store, key;

  assign is_fetch = (kind == KIND_FETCH);
  assign is_store = (kind == KIND_STORE);
  assign key      = user ? desc[BIT_KU] : desc[BIT_KS];

  always_comb begin
    rsp = '0;
    if (real_mode) begin
      rsp.ok = 1'b1;
      rsp.rd = 1'b1;
      rsp.wr = 1'b1;
      rsp.ex = 1'b1;
      rsp.pa = ea;
    end else if (desc[BIT_DS]) begin
      if (is_fetch) begin
        rsp.fault = FLT_INSTR;
        rsp.syn   = SYN_NOEXEC;
      end else begin
        unique case (cls)
          CLS_FP: begin
            rsp.fault = FLT_ALIGN;
            rsp.syn   = ALIGN_FP_CODE;
            rsp.far   = ea;
          end
          CLS_RESV: begin
            rsp.fault = FLT_DATA;
            rsp.syn   = is_store ? SYN_RESV_ST : SYN_RESV_LD;
            rsp.far   = ea;
          end
          CLS_CACHE: begin
            rsp.ok = 1'b1;
            rsp.pa = ea;
          end
          CLS_EXT: begin
            rsp.fault = FLT_DATA;
            rsp.syn   = is_store ? SYN_EXT_ST : SYN_EXT_LD;
            rsp.far   = ea;
          end
          default: begin
            if (is_store && !key) begin
              rsp.fault = FLT_DATA;
              rsp.syn   = SYN_PROT_ST;
              rsp.far   = ea;
            end else begin
              rsp.ok = 1'b1;
              rsp.pa = ea;
              rsp.rd = 1'b1;
              rsp.wr = key;
            end
          end
        endcase
      end
    end else if (is_fetch && desc[BIT_NX]) begin
      rsp.fault = FLT_INSTR;
      rsp.syn   = SYN_NOEXEC;
    end else begin
      rsp.walk = 1'b1;
    end
  end
endmodule

// File: rtl/ds_access_checker.sv
module ds_access_checker
  import dsc_pkg::*;
#(
  parameter logic [31:0] ALIGN_FP_CODE = 32'h0001_0000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_ea,
  input  logic [1:0]                req_kind,
  input  logic [2:0]                req_class,
  input  logic                      req_user,
  input  logic                      req_real,
  input  logic [NUM_SEG*DESC_W-1:0] seg_file,
  output logic                      rsp_valid,
  output logic                      rsp_ok,
  output logic                      rsp_walk,
  output logic [1:0]                rsp_fault,
  output logic [ADDR_W-1:0]         rsp_pa,
  output logic                      rsp_rd,
  output logic                      rsp_wr,
  output logic                      rsp_ex,
  output logic [31:0]               rsp_syndrome,
  output logic [ADDR_W-1:0]         rsp_far
);
  logic [DESC_W-1:0] desc;
  dsc_rsp_t          dec, rsp_d, rsp_q;
  logic              valid_d, valid_q;

  dsc_seg_select #(.SEL_W(SEL_W), .DESC_W(DESC_W)) u_sel (
    .seg_file (seg_file),
    .sel      (req_ea[ADDR_W-1 -: SEL_W]),
    .desc     (desc)
  );

  dsc_decide #(.ALIGN_FP_CODE(ALIGN_FP_CODE)) u_dec (
    .ea        (req_ea),
    .desc      (desc),
    .kind      (req_kind),
    .cls       (req_class),
    .user      (req_user),
    .real_mode (req_real),
    .rsp       (dec)
  );

  // next state
  always_comb begin
    valid_d = req_valid;
    rsp_d   = req_valid ? dec : rsp_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rsp_q   <= '0;
    end else begin
      valid_q <= valid_d;
      rsp_q   <= rsp_d;
    end
  end

  assign rsp_valid    = valid_q;
  assign rsp_ok       = rsp_q.ok;
  assign rsp_walk     = rsp_q.walk;
  assign rsp_fault    = rsp_q.fault;
  assign rsp_pa       = rsp_q.pa;
  assign rsp_rd       = rsp_q.rd;
  assign rsp_wr       = rsp_q.wr;
  assign rsp_ex       = rsp_q.ex;
  assign rsp_syndrome = rsp_q.syn;
  assign rsp_far      = rsp_q.far;
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_ea,
  input logic        req_real,
  input logic        rsp_valid,
  input logic        rsp_ok,
  input logic        rsp_walk,
  input logic [1:0]  rsp_fault,
  input logic [31:0] rsp_pa,
  input logic        rsp_rd,
  input logic        rsp_wr,
  input logic        rsp_ex,
  input logic [31:0] rsp_syndrome,
  input logic [31:0] rsp_far
);
  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_ok, rsp_walk, rsp_fault != 2'd0}) == 1));

  assert_real_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_real) |=> (rsp_ok && rsp_rd && rsp_wr && rsp_ex && rsp_pa == $past(req_ea)));

  assert_ex_real_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ex) |-> rsp_ok);

  assert_ifetch_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd1) |-> (rsp_syndrome == 32'h1000_0000));

  assert_far_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault[1]) |-> (rsp_far == $past(req_ea)));

  assert_wr_needs_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_wr) |-> rsp_rd);
endmodule

bind ds_access_checker dsc_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ea       (req_ea),
  .req_real     (req_real),
  .rsp_valid    (rsp_valid),
  .rsp_ok       (rsp_ok),
  .rsp_walk     (rsp_walk),
  .rsp_fault    (rsp_fault),
  .rsp_pa       (rsp_pa),
  .rsp_rd       (rsp_rd),
  .rsp_wr       (rsp_wr),
  .rsp_ex       (rsp_ex),
  .rsp_syndrome (rsp_syndrome),
  .rsp_far      (rsp_far)
);

// File: tb/ds_access_checker_tb.sv
`timescale 1ns/1ps
module ds_access_checker_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic [31:0]  req_ea;
  logic [1:0]   req_kind;
  logic [2:0]   req_class;
  logic         req_user;
  logic         req_real;
  logic [511:0] seg_file;
  logic         rsp_valid, rsp_ok, rsp_walk, rsp_rd, rsp_wr, rsp_ex;
  logic [1:0]   rsp_fault;
  logic [31:0]  rsp_pa, rsp_syndrome, rsp_far;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ds_access_checker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
    .req_kind(req_kind), .req_class(req_class), .req_user(req_user),
    .req_real(req_real), .seg_file(seg_file), .rsp_valid(rsp_valid),
    .rsp_ok(rsp_ok), .rsp_walk(rsp_walk), .rsp_fault(rsp_fault),
    .rsp_pa(rsp_pa), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex),
    .rsp_syndrome(rsp_syndrome), .rsp_far(rsp_far)
  );

  typedef struct packed {
    logic [7:0]  tag;
    logic [31:0] ea;
    logic [1:0]  kind;
    logic [2:0]  cls;
    logic        user;
    logic        rl;
    logic        ok;
    logic        walk;
    logic [1:0]  flt;
    logic [31:0] syn;
    logic        rd;
    logic        wr;
  } vec_t;

  // seg0 plain, seg1 DS Ks=1 Ku=0, seg2 DS Ks=0 Ku=1, seg3 plain NX, others DS both keys
  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{8'd5,  32'h0123_4560, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 32'h0,         1'b0, 1'b0}, // R5
    '{8'd2,  32'h1ABC_0000, 2'd2, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 32'h0,         1'b1, 1'b1}, // R2
    '{8'd3,  32'h1000_0040, 2'd2, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 32'h1000_0000, 1'b0, 1'b0}, // R3
    '{8'd3,  32'h1000_0044, 2'd2, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 32'h1000_0000, 1'b0, 1'b0}, // R3 fetch beats class
    '{8'd4,  32'h3000_0100, 2'd2, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 32'h1000_0000, 1'b0, 1'b0}, // R4
    '{8'd5,  32'h3000_0200, 2'd1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 32'h0,         1'b0, 1'b0}, // R5 NX only for fetch
    '{8'd6,  32'h1000_0008, 2'd0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 32'h0001_0000, 1'b0, 1'b0}, // R6
    '{8'd7,  32'h1000_0010, 2'd1, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 32'h0600_0000, 1'b0, 1'b0}, // R7 store
    '{8'd7,  32'h1000_0014, 2'd0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 32'h0400_0000, 1'b0, 1'b0}, // R7 load
    '{8'd8,  32'h2000_0020, 2'd1, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 32'h0610_0000, 1'b0, 1'b0}, // R8 store
    '{8'd8,  32'h2000_0024, 2'd0, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 32'h0410_0000, 1'b0, 1'b0}, // R8 load
    '{8'd9,  32'h1000_0080, 2'd1, 3'd3, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0,         1'b0, 1'b0}, // R9
    '{8'd10, 32'h1000_0100, 2'd1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0,         1'b1, 1'b1}, // R10 priv Ks=1
    '{8'd10, 32'h1000_0104, 2'd1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 32'h0A00_0000, 1'b0, 1'b0}, // R10 user Ku=0
    '{8'd10, 32'h1000_0108, 2'd0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0,         1'b1, 1'b0}, // R10 read only
    '{8'd10, 32'h2000_0200, 2'd1, 3'd7, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0,         1'b1, 1'b1}, // R10 class 7, user Ku=1
    '{8'd10, 32'h2000_0204, 2'd1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 32'h0A00_0000, 1'b0, 1'b0}, // R10 priv Ks=0
    '{8'd1,  32'h5000_0300, 2'd1, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0,         1'b1, 1'b1}  // R1 seg5
  };

  task automatic chk(input int tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic drive(input logic [31:0] ea, input logic [1:0] k, input logic [2:0] c,
                       input logic u, input logic r);
    req_valid = 1'b1; req_ea = ea; req_kind = k; req_class = c; req_user = u; req_real = r;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_ea = '0; req_kind = '0; req_class = '0;
    req_user = 1'b0; req_real = 1'b0;
    for (int i = 0; i < 16; i++) begin
      logic [31:0] d;
      case (i)
        0: d = 32'h0000_0000;
        1: d = 32'hC000_0000;
        2: d = 32'hA000_0000;
        3: d = 32'h1000_0000;
        default: d = 32'hE000_0000;
      endcase
      seg_file[i*32 +: 32] = d | 32'(i);
    end
    // R12 reset state
    req_valid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(12, "rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      logic [31:0] exp_pa, exp_far;
      t = TBL[v];
      drive(t.ea, t.kind, t.cls, t.user, t.rl);
      exp_pa  = t.ok ? t.ea : 32'd0;
      exp_far = t.flt[1] ? t.ea : 32'd0;
      chk(11, "valid", {31'd0, rsp_valid}, 32'd1);
      chk(t.tag, "ok", {31'd0, rsp_ok}, {31'd0, t.ok});
      chk(t.tag, "walk", {31'd0, rsp_walk}, {31'd0, t.walk});
      chk(t.tag, "fault", {30'd0, rsp_fault}, {30'd0, t.flt});
      chk(t.tag, "syndrome", rsp_syndrome, t.syn);
      chk(t.tag, "rd", {31'd0, rsp_rd}, {31'd0, t.rd});
      chk(t.tag, "wr", {31'd0, rsp_wr}, {31'd0, t.wr});
      chk(t.tag, "ex", {31'd0, rsp_ex}, {31'd0, t.rl});
      chk(t.tag, "pa", rsp_pa, exp_pa);
      chk(t.tag, "far", rsp_far, exp_far);
    end

    // R11: no request -> no response next cycle
    @(posedge clk); @(negedge clk);
    chk(11, "idle valid", {31'd0, rsp_valid}, 32'd0);

    // R2: real mode overrides a direct-store fetch
    drive(32'h1000_0400, 2'd2, 3'd1, 1'b1, 1'b1);
    chk(2, "real on DS ok", {31'd0, rsp_ok}, 32'd1);
    chk(2, "real on DS fault", {30'd0, rsp_fault}, 32'd0);
    chk(2, "real on DS pa", rsp_pa, 32'h1000_0400);

    // R1: same offset, seg 2 vs seg 1 for a user store pick different keys
    drive(32'h2000_0000, 2'd1, 3'd0, 1'b1, 1'b0);
    chk(1, "seg2 user store ok", {31'd0, rsp_ok}, 32'd1);
    drive(32'h1000_0000, 2'd1, 3'd0, 1'b1, 1'b0);
    chk(1, "seg1 user store fault", {30'd0, rsp_fault}, 32'd2);

    // R12: reset mid-stream clears valid
    req_valid = 1'b1; req_ea = 32'h1000_0000;
    rst_n = 1'b0;
    #1;
    chk(12, "async reset valid", {31'd0, rsp_valid}, 32'd0);
    req_valid = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule